// File: doc/BRIEF.md
# Programmable Parallel Bus Strobe Sequencer

This block turns one host request into a single asynchronous access on a parallel device bus for one chip-select region. The host offers an address, write data and a direction flag and holds its request high. The sequencer then steps the device side through five timed stretches. First the address alone is driven. Then chip select rises, followed by a delay. Next comes the read or write strobe. The strobe is followed by a hold with chip select still high, and finally by an idle gap before the next access may start. A one-clock ready pulse then goes back to the host, carrying the read data for a read.

Every stretch is given in timing units. A 2-bit multiplier code sets how many clocks make one unit. The strobe, hold and gap fields hold the unit count minus one. The address-setup and select-to-strobe fields hold the count directly, and a zero there skips that stretch. Reads and writes each have their own strobe width and hold. An optional wait mode keeps the strobe on until the device raises its ready input, then keeps it on for a programmed number of extra units. The settings are captured when a request is accepted, so they can be reprogrammed while an access is in flight.

Top module: `pbus_strobe_seq`

## Requirements
- R1: The multiplier code sets the clocks per timing unit: code 0 gives 4, code 1 gives 1, code 2 gives 2 and code 3 gives 8. Every phase length is its unit count times this value.
- R2: Each access runs in a fixed order: address only, then chip select, then strobe, then hold with chip select high, then gap with chip select low. The address stays constant from acceptance until ready.
- R3: The address-setup phase lasts cfg_setup units and the select-to-strobe phase lasts cfg_csdly units, with 0 skipping the phase. The gap after chip select falls lasts cfg_pause+1 units.
- R4: A read raises only bus_rd, for cfg_rd_width+1 units, then holds for cfg_rd_hold+1 units. A write raises only bus_wr, for cfg_wr_width+1 units, then holds for cfg_wr_hold+1 units.
- R5: With cfg_waitm set, the strobe lasts at least its programmed width and does not end until bus_ready has been seen high. After that it continues for cfg_wext more units. With cfg_waitm clear, bus_ready and cfg_wext have no effect.
- R6: For a read, bus_din is captured on the clock edge at which the strobe ends. The captured value is on host_rdata when host_rdy is high.
- R7: While cfg_en is low, a request starts no access: chip select stays low and host_rdy never rises.
- R8: host_rdy is high for exactly one clock, in the cycle after the gap ends. A request that is seen during that cycle is not accepted.
- R9: All configuration inputs are sampled in the cycle a request is accepted. Changes made during an access affect only later accesses.
- R10: bus_dout_en is high, with bus_dout equal to the host write data, exactly while chip select is high during a write. It stays low during reads.
- R11: After reset, chip select, both strobes, bus_dout_en and host_rdy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Access request, held until host_rdy |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Access address |
| host_wdata | input | DW | Write data |
| host_rdy | output | 1 | One-clock completion pulse |
| host_rdata | output | DW | Captured read data |
| cfg_en | input | 1 | Region enable |
| cfg_mult | input | 2 | Multiplier code |
| cfg_setup | input | FW | Address-setup units |
| cfg_csdly | input | FW | Select-to-strobe units |
| cfg_rd_width | input | FW | Read strobe units minus one |
| cfg_wr_width | input | FW | Write strobe units minus one |
| cfg_rd_hold | input | FW | Read hold units minus one |
| cfg_wr_hold | input | FW | Write hold units minus one |
| cfg_pause | input | FW | Gap units minus one |
| cfg_waitm | input | 1 | Wait-for-ready mode |
| cfg_wext | input | FW | Extra strobe units after ready |
| bus_addr | output | AW | Device address |
| bus_cs | output | 1 | Chip select, active high |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_dout | output | DW | Write data toward the device |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DW | Read data from the device |
| bus_ready | input | 1 | Device ready |

## Verification
The assertions assume that the host keeps host_req and its address and data steady from the request until the ready pulse. They also assume the reset is held for at least one clock edge. The bench follows both rules: it raises a request only in an idle cycle and drops it in the cycle it sees ready, except in the one directed case that holds it through the ready cycle on purpose. bus_ready is driven only during the strobe, and it rises after a chosen number of strobe cycles, so the wait-mode stall is always finite. bus_din carries the valid value only during strobe cycles and its inverse otherwise, so a capture at any other edge shows up as a wrong read.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_CSDLY  = 3'd2,
        ST_STROBE = 3'd3,
        ST_WEXT   = 3'd4,
        ST_HOLD   = 3'd5,
        ST_PAUSE  = 3'd6
    } phase_e;

    // Slot numbers of the per-phase length calculators
    localparam int PH_SETUP = 0;
    localparam int PH_CSDLY = 1;
    localparam int PH_STB   = 2;
    localparam int PH_WEXT  = 3;
    localparam int PH_HOLD  = 4;
    localparam int PH_PAUSE = 5;
    localparam int PH_NUM   = 6;

endpackage

// File: rtl/pbus_mult_dec.sv
module pbus_mult_dec (
    input  logic [1:0] code,
    output logic [1:0] shift
);
    // Non-monotonic code: 0 -> x4, 1 -> x1, 2 -> x2, 3 -> x8
    always_comb begin
        case (code)
            2'd0:    shift = 2'd2;
            2'd1:    shift = 2'd0;
            2'd2:    shift = 2'd1;
            default: shift = 2'd3;
        endcase
    end
endmodule

// File: rtl/pbus_len_calc.sv
module pbus_len_calc #(
    parameter int FW       = 4,
    parameter int CW       = FW + 4,
    parameter bit PLUS_ONE = 1'b0
) (
    input  logic [FW-1:0] units,
    input  logic [1:0]    shift,
    output logic [CW-1:0] cycles
);
    logic [CW-1:0] ext;

    always_comb begin
        ext    = CW'(units) + (PLUS_ONE ? CW'(1) : CW'(0));
        cycles = ext << shift;
    end
endmodule

// File: rtl/pbus_seq_ctrl.sv
module pbus_seq_ctrl
    import pbus_pkg::*;
#(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_mult,
    input  logic [FW-1:0] cfg_setup,
    input  logic [FW-1:0] cfg_csdly,
    input  logic [FW-1:0] cfg_rd_width,
    input  logic [FW-1:0] cfg_wr_width,
    input  logic [FW-1:0] cfg_rd_hold,
    input  logic [FW-1:0] cfg_wr_hold,
    input  logic [FW-1:0] cfg_pause,
    input  logic          cfg_waitm,
    input  logic [FW-1:0] cfg_wext,
    input  logic          dev_rdy,
    output logic          accept,
    output logic          capture,
    output logic          bus_cs,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_den,
    output logic          host_rdy
);
    localparam int CW = FW + 4;
    // Strobe, hold and gap fields are stored as count minus one
    localparam logic [PH_NUM-1:0] PLUS1 = (PH_NUM)'((1 << PH_STB) | (1 << PH_HOLD) | (1 << PH_PAUSE));

    typedef struct packed {
        logic          wr;
        logic          waitm;
        logic [1:0]    mult;
        logic [FW-1:0] setup;
        logic [FW-1:0] csdly;
        logic [FW-1:0] rd_w;
        logic [FW-1:0] wr_w;
        logic [FW-1:0] rd_h;
        logic [FW-1:0] wr_h;
        logic [FW-1:0] pause;
        logic [FW-1:0] wext;
    } cfg_t;

    typedef struct packed {
        phase_e        st;
        logic [CW-1:0] cnt;
        cfg_t          cfg;
        logic          rdy;
    } regs_t;

    regs_t q, d;
    cfg_t  cfg_in, eff;
    logic [1:0]    shift;
    logic [FW-1:0] units [PH_NUM];
    logic [CW-1:0] len   [PH_NUM];

    always_comb begin
        cfg_in.wr    = req_wr;
        cfg_in.waitm = cfg_waitm;
        cfg_in.mult  = cfg_mult;
        cfg_in.setup = cfg_setup;
        cfg_in.csdly = cfg_csdly;
        cfg_in.rd_w  = cfg_rd_width;
        cfg_in.wr_w  = cfg_wr_width;
        cfg_in.rd_h  = cfg_rd_hold;
        cfg_in.wr_h  = cfg_wr_hold;
        cfg_in.pause = cfg_pause;
        cfg_in.wext  = cfg_wext;
        // Live settings are used only on the accepting cycle
        eff = (q.st == ST_IDLE) ? cfg_in : q.cfg;
        units[PH_SETUP] = eff.setup;
        units[PH_CSDLY] = eff.csdly;
        units[PH_STB]   = eff.wr ? eff.wr_w : eff.rd_w;
        units[PH_WEXT]  = eff.wext;
        units[PH_HOLD]  = eff.wr ? eff.wr_h : eff.rd_h;
        units[PH_PAUSE] = eff.pause;
    end

    pbus_mult_dec u_mult (
        .code  (eff.mult),
        .shift (shift)
    );

    for (genvar i = 0; i < PH_NUM; i++) begin : g_len
        pbus_len_calc #(
            .FW       (FW),
            .CW       (CW),
            .PLUS_ONE (PLUS1[i])
        ) u_len (
            .units  (units[i]),
            .shift  (shift),
            .cycles (len[i])
        );
    end

    always_comb begin
        d       = q;
        d.rdy   = 1'b0;
        accept  = 1'b0;
        capture = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req && cfg_en && !q.rdy) begin
                    accept = 1'b1;
                    d.cfg  = cfg_in;
                    if (len[PH_SETUP] != '0) begin
                        d.st  = ST_SETUP;
                        d.cnt = len[PH_SETUP] - CW'(1);
                    end else if (len[PH_CSDLY] != '0) begin
                        d.st  = ST_CSDLY;
                        d.cnt = len[PH_CSDLY] - CW'(1);
                    end else begin
                        d.st  = ST_STROBE;
                        d.cnt = len[PH_STB] - CW'(1);
                    end
                end
            end
            ST_SETUP: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CW'(1);
                end else if (len[PH_CSDLY] != '0) begin
                    d.st  = ST_CSDLY;
                    d.cnt = len[PH_CSDLY] - CW'(1);
                end else begin
                    d.st  = ST_STROBE;
                    d.cnt = len[PH_STB] - CW'(1);
                end
            end
            ST_CSDLY: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CW'(1);
                end else begin
                    d.st  = ST_STROBE;
                    d.cnt = len[PH_STB] - CW'(1);
                end
            end
            ST_STROBE: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CW'(1);
                end else if (q.cfg.waitm && !dev_rdy) begin
                    d.st = ST_STROBE;
                end else if (q.cfg.waitm && len[PH_WEXT] != '0) begin
                    d.st  = ST_WEXT;
                    d.cnt = len[PH_WEXT] - CW'(1);
                end else begin
                    capture = !q.cfg.wr;
                    d.st    = ST_HOLD;
                    d.cnt   = len[PH_HOLD] - CW'(1);
                end
            end
            ST_WEXT: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CW'(1);
                end else begin
                    capture = !q.cfg.wr;
                    d.st    = ST_HOLD;
                    d.cnt   = len[PH_HOLD] - CW'(1);
                end
            end
            ST_HOLD: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CW'(1);
                end else begin
                    d.st  = ST_PAUSE;
                    d.cnt = len[PH_PAUSE] - CW'(1);
                end
            end
            ST_PAUSE: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CW'(1);
                end else begin
                    d.st  = ST_IDLE;
                    d.rdy = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic stb;
    always_comb begin
        bus_cs   = (q.st == ST_CSDLY) || (q.st == ST_STROBE) ||
                   (q.st == ST_WEXT)  || (q.st == ST_HOLD);
        stb      = (q.st == ST_STROBE) || (q.st == ST_WEXT);
        bus_rd   = stb && !q.cfg.wr;
        bus_wr   = stb &&  q.cfg.wr;
        bus_den  = bus_cs && q.cfg.wr;
        host_rdy = q.rdy;
    end

    phase_e st_q;
    cfg_t   cfg_q;
    assign st_q  = q.st;
    assign cfg_q = q.cfg;

    // R4: never both strobes
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    // R8: ready is a single-cycle pulse and blocks a restart
    p_rdy_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |=> !host_rdy);
    p_rdy_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |=> (st_q == ST_IDLE));
    // R5: in wait mode a finished strobe count stalls while the device is not ready
    p_wait_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STROBE && q.cnt == '0 && cfg_q.waitm && !dev_rdy) |=> (st_q == ST_STROBE));
    // R7: disabled region stays idle
    p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !cfg_en) |=> (!bus_cs && !host_rdy));
    // R9: sampled settings are frozen during an access
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(cfg_q));
endmodule

// File: rtl/pbus_data_path.sv
module pbus_data_path #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] bus_din,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic [DW-1:0] host_rdata
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } dp_t;

    dp_t q, d;

    always_comb begin
        d = q;
        if (accept) begin
            d.addr  = host_addr;
            d.wdata = host_wdata;
        end
        if (capture) d.rdata = bus_din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_addr   = q.addr;
    assign bus_dout   = q.wdata;
    assign host_rdata = q.rdata;
endmodule

// File: rtl/pbus_strobe_seq.sv
module pbus_strobe_seq #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_rdy,
    output logic [DW-1:0] host_rdata,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_mult,
    input  logic [FW-1:0] cfg_setup,
    input  logic [FW-1:0] cfg_csdly,
    input  logic [FW-1:0] cfg_rd_width,
    input  logic [FW-1:0] cfg_wr_width,
    input  logic [FW-1:0] cfg_rd_hold,
    input  logic [FW-1:0] cfg_wr_hold,
    input  logic [FW-1:0] cfg_pause,
    input  logic          cfg_waitm,
    input  logic [FW-1:0] cfg_wext,
    output logic [AW-1:0] bus_addr,
    output logic          bus_cs,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_ready
);
    logic accept, capture;

    pbus_seq_ctrl #(.FW(FW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (host_req),
        .req_wr       (host_wr),
        .cfg_en       (cfg_en),
        .cfg_mult     (cfg_mult),
        .cfg_setup    (cfg_setup),
        .cfg_csdly    (cfg_csdly),
        .cfg_rd_width (cfg_rd_width),
        .cfg_wr_width (cfg_wr_width),
        .cfg_rd_hold  (cfg_rd_hold),
        .cfg_wr_hold  (cfg_wr_hold),
        .cfg_pause    (cfg_pause),
        .cfg_waitm    (cfg_waitm),
        .cfg_wext     (cfg_wext),
        .dev_rdy      (bus_ready),
        .accept       (accept),
        .capture      (capture),
        .bus_cs       (bus_cs),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_den      (bus_dout_en),
        .host_rdy     (host_rdy)
    );

    pbus_data_path #(.AW(AW), .DW(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .bus_din    (bus_din),
        .bus_addr   (bus_addr),
        .bus_dout   (bus_dout),
        .host_rdata (host_rdata)
    );

    // R2: address held steady while chip select is asserted
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && $past(bus_cs)) |-> $stable(bus_addr));
    // R10: write data driven only inside chip select and never during a read strobe
    p_den_in_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> (bus_cs && !bus_rd));
endmodule

// File: tb/tb_pbus_strobe_seq.sv
module tb_pbus_strobe_seq;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int FW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 1'b0, host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic host_rdy;
    logic [DW-1:0] host_rdata;
    logic cfg_en = 1'b1;
    logic [1:0] cfg_mult = 2'd1;
    logic [FW-1:0] cfg_setup = '0, cfg_csdly = '0, cfg_rd_width = '0, cfg_wr_width = '0;
    logic [FW-1:0] cfg_rd_hold = '0, cfg_wr_hold = '0, cfg_pause = '0, cfg_wext = '0;
    logic cfg_waitm = 1'b0;
    logic [AW-1:0] bus_addr;
    logic bus_cs, bus_rd, bus_wr, bus_dout_en;
    logic [DW-1:0] bus_dout;
    logic [DW-1:0] bus_din = '0;
    logic bus_ready = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pbus_strobe_seq #(.AW(AW), .DW(DW), .FW(FW)) dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int unit_clk(input logic [1:0] code);
        case (code)
            2'd0: return 4;
            2'd1: return 1;
            2'd2: return 2;
            default: return 8;
        endcase
    endfunction

    task automatic randomize_cfg();
        cfg_mult     = 2'($urandom_range(0, 3));
        cfg_setup    = FW'($urandom);
        cfg_csdly    = FW'($urandom);
        cfg_rd_width = FW'($urandom);
        cfg_wr_width = FW'($urandom);
        cfg_rd_hold  = FW'($urandom);
        cfg_wr_hold  = FW'($urandom);
        cfg_pause    = FW'($urandom);
        cfg_wext     = FW'($urandom);
        cfg_waitm    = 1'($urandom);
    endtask

    // One access; expected lengths computed from the settings present at the request
    task automatic run_access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                              input logic [DW-1:0] rv, input int dly, input bit scramble,
                              input string tot_tag);
        int p, e_pre, e_csd, e_stb, e_hld, e_pau, e_tot, stbmin;
        int tot, pre, csd, stb, hld, pau, den, badaddr, baddout, wrongdir;
        bit seen_cs, seen_stb;
        p      = unit_clk(cfg_mult);
        e_pre  = int'(cfg_setup) * p;
        e_csd  = int'(cfg_csdly) * p;
        stbmin = (int'(wr ? cfg_wr_width : cfg_rd_width) + 1) * p;
        if (cfg_waitm) e_stb = ((dly > stbmin) ? dly : stbmin) + int'(cfg_wext) * p;
        else           e_stb = stbmin;
        e_hld  = (int'(wr ? cfg_wr_hold : cfg_rd_hold) + 1) * p;
        e_pau  = (int'(cfg_pause) + 1) * p;
        e_tot  = e_pre + e_csd + e_stb + e_hld + e_pau;
        tot = 0; pre = 0; csd = 0; stb = 0; hld = 0; pau = 0; den = 0;
        badaddr = 0; baddout = 0; wrongdir = 0; seen_cs = 0; seen_stb = 0;

        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = wd;
        bus_ready = 1'b0; bus_din = ~rv;
        @(negedge clk);
        if (scramble) randomize_cfg();
        while (!host_rdy && tot < 5000) begin
            tot++;
            if (bus_addr !== a) badaddr++;
            if (bus_cs) begin
                seen_cs = 1'b1;
                if (bus_rd || bus_wr) begin
                    seen_stb = 1'b1;
                    stb++;
                    if (bus_wr !== wr || bus_rd !== !wr) wrongdir++;
                end else if (!seen_stb) csd++;
                else hld++;
            end else if (!seen_cs) pre++;
            else pau++;
            if (bus_dout_en) begin
                den++;
                if (bus_dout !== wd) baddout++;
            end
            bus_din   = (bus_rd || bus_wr) ? rv : ~rv;
            bus_ready = (bus_rd || bus_wr) && (stb >= dly);
            @(negedge clk);
        end
        bus_ready = 1'b0;
        host_req  = 1'b0;
        check(pre == e_pre, "R3 setup cycles", pre, e_pre);
        check(csd == e_csd, "R3 cs-to-strobe cycles", csd, e_csd);
        check(stb == e_stb, cfg_waitm ? "R5 strobe cycles (wait mode)" : "R4 strobe cycles", stb, e_stb);
        check(wrongdir == 0, "R4 strobe direction", wrongdir, 0);
        check(hld == e_hld, "R4 hold cycles", hld, e_hld);
        check(pau == e_pau, "R3 pause cycles", pau, e_pau);
        check(tot == e_tot, tot_tag, tot, e_tot);
        check(badaddr == 0, "R2 address steady", badaddr, 0);
        check(den == (wr ? e_csd + e_stb + e_hld : 0), "R10 drive enable cycles",
              den, wr ? e_csd + e_stb + e_hld : 0);
        check(baddout == 0, "R10 write data value", baddout, 0);
        if (!wr) check(host_rdata === rv, "R6 read data with ready", int'(host_rdata), int'(rv));
        @(negedge clk);
        check(!host_rdy && !bus_cs, "R8 ready single pulse", int'(host_rdy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int bad;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!bus_cs && !bus_rd && !bus_wr && !bus_dout_en && !host_rdy,
              "R11 reset outputs", int'({bus_cs, bus_rd, bus_wr, bus_dout_en, host_rdy}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: same fields under every multiplier code
        for (int c = 0; c < 4; c++) begin
            cfg_mult = 2'(c); cfg_setup = 4'd2; cfg_csdly = 4'd1; cfg_rd_width = 4'd3;
            cfg_rd_hold = 4'd0; cfg_pause = 4'd1; cfg_waitm = 1'b0;
            run_access(1'b0, 16'h1230 + 16'(c), 16'h0, 16'hA5C3 ^ 16'(c), 1, 1'b0, "R1 total cycles");
        end

        // R3: zero setup and zero delay skip their phases; R4 write with minimum fields
        cfg_mult = 2'd1; cfg_setup = '0; cfg_csdly = '0; cfg_wr_width = '0;
        cfg_wr_hold = '0; cfg_pause = '0;
        run_access(1'b1, 16'hBEEF, 16'h5A5A, 16'h0, 1, 1'b0, "R3 total cycles minimum");

        // R5: wait mode with a late ready and an extension
        cfg_mult = 2'd2; cfg_setup = 4'd1; cfg_csdly = 4'd1; cfg_rd_width = 4'd1;
        cfg_rd_hold = 4'd1; cfg_waitm = 1'b1; cfg_wext = 4'd2;
        run_access(1'b0, 16'h0042, 16'h0, 16'h3C3C, 23, 1'b0, "R5 total cycles");
        // R5: ready ignored without wait mode
        cfg_waitm = 1'b0;
        run_access(1'b0, 16'h0043, 16'h0, 16'hC3C3, 40, 1'b0, "R5 total cycles no wait");

        // R9: settings changed right after acceptance
        cfg_mult = 2'd3; cfg_setup = 4'd1; cfg_csdly = 4'd2; cfg_wr_width = 4'd2;
        cfg_wr_hold = 4'd1; cfg_pause = 4'd0; cfg_waitm = 1'b0;
        run_access(1'b1, 16'h7777, 16'h1357, 16'h0, 1, 1'b1, "R9 total cycles after change");

        // R7: disabled region ignores a held request
        cfg_en = 1'b0; cfg_mult = 2'd1; cfg_setup = '0; cfg_csdly = '0; cfg_waitm = 1'b0;
        host_req = 1'b1; host_wr = 1'b0; bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_cs || host_rdy) bad++;
        end
        host_req = 1'b0;
        check(bad == 0, "R7 disabled region activity", bad, 0);
        cfg_en = 1'b1;
        @(negedge clk);

        // R8: request held through the ready cycle is not taken
        cfg_rd_width = '0; cfg_rd_hold = '0; cfg_pause = '0;
        host_req = 1'b1; host_wr = 1'b0; host_addr = 16'h0101;
        bad = 0;
        for (int i = 0; i < 50 && !host_rdy; i++) @(negedge clk);
        check(host_rdy == 1'b1, "R8 ready reached", int'(host_rdy), 1);
        @(negedge clk);
        check(!bus_cs && !host_rdy, "R8 no restart in ready cycle", int'(bus_cs), 0);
        host_req = 1'b0;
        @(negedge clk);

        // Constrained random mix of reads and writes
        for (int v = 0; v < 120; v++) begin
            randomize_cfg();
            run_access(1'($urandom), AW'($urandom), DW'($urandom), DW'($urandom),
                       $urandom_range(1, 20), 1'($urandom_range(0, 3) == 0), "R1 total cycles random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule